// File: doc/BRIEF.md
# Paged Processor Register Interface for a Time-Slot Switch

This block is the processor-facing port of a time-slot interchange switch. An 8-bit asynchronous processor bus (six address lines, an active-high data strobe, a read/write select, an active-low chip select and a bidirectional data bus) reaches one control register and three memories owned by the switching datapath. These are the data memory, the low half of connection memory and the high half of connection memory. The memories are seen through a 32-entry window. The control register picks which memory and which stream page the window shows. An active-low acknowledge tells the processor when its transfer is finished.

Chip select and strobe are brought into the bit-clock domain through a two-stage synchronizer. An access starts on the synchronized rising edge of the strobe. Control register accesses complete at once. A memory access waits for a slot that the datapath marks as free, so the switching reads are never disturbed. It then issues a single-cycle request on a simple memory port and captures any read data. The acknowledge stays low until the processor lets go of the strobe or the chip select.

A split mode in the control register sends window reads to the data memory and window writes to connection memory low, whatever the memory-select field holds. The global processor-mode bit is brought out to the datapath.

Top module: `tsx_cpu_port`

## Requirements
- R1: After reset the control register is 0x00, `ack_n` is high, `mem_req` is low and `glob_proc_en` is low. A control register read returns 0x00.
- R2: With `addr[5]`=0 every access goes to the control register and `addr[4:0]` has no effect. A write at address 0x1F is read back at address 0x00.
- R3: The control register fields are: bits 2:0 the stream page, bits 4:3 the memory select, bit 6 the global processor-mode enable driven on `glob_proc_en`, and bit 7 split mode. Bit 5 is not stored and reads 0. `glob_proc_en` changes only on a control register write.
- R4: With `addr[5]`=1 the memory address is {stream page, `addr[4:0]`}, so the index is stream*32+channel.
- R5: The memory-select codes are 01 data memory, 10 connection memory low and 11 connection memory high, and the same code appears on `mem_tgt`. Data memory is read-only: a window write to it issues no memory request and changes nothing. Code 00 is reserved: it issues no request, reads return 0x00 and writes change nothing. Both cases are still acknowledged.
- R6: A read of connection memory high returns the 3 stored bits in bits 2:0, with bits 7:3 zero.
- R7: While bit 7 is set, window reads come from data memory and window writes go to connection memory low. The memory-select field has no effect until the control register is written again.
- R8: Counting clock edges from the first edge after the strobe rises with chip select low, a control register access pulls `ack_n` low at edge 3. A memory access with `slot_free` held high does so at edge 5.
- R9: `mem_req` is high only in a cycle with `slot_free` high, and only for one cycle per access. While `slot_free` stays low the access waits and is not acknowledged. Once the slot frees, `ack_n` falls two edges later.
- R10: `ack_n` stays low as long as the strobe and chip select are held, and it returns high by the third edge after either is released. The data bus is driven only while a read is acknowledged. A strobe with `cs_n` high starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the switch |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Processor address; bit 5 chooses control register (0) or memory window (1) |
| strobe | input | 1 | Active-high data strobe, asynchronous |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| dbus | inout | 8 | Bidirectional processor data bus |
| ack_n | output | 1 | Active-low transfer acknowledge |
| slot_free | input | 1 | Datapath marks a cycle in which the memories may be used by the processor |
| mem_req | output | 1 | Single-cycle memory access request |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | Target memory: 01 data, 10 connection low, 11 connection high |
| mem_addr | output | 8 | Memory index {stream, channel} |
| mem_wdata | output | 8 | Write data |
| dm_rdata | input | 8 | Data memory read data, valid the cycle after a request |
| cml_rdata | input | 8 | Connection memory low read data, valid the cycle after a request |
| cmh_rdata | input | 3 | Connection memory high read data, valid the cycle after a request |
| glob_proc_en | output | 1 | Global processor-mode enable from the control register |

## Verification
The hardest case to reach from the ports is a memory access parked in the waiting state. The strobe is already synchronized and the address is latched, but the datapath refuses a slot, so the request and the acknowledge must both stay quiet for an arbitrary time. The bench holds `slot_free` low before raising the strobe and watches for ten cycles, checking that no request pulse appears and that `ack_n` stays high. It then frees the slot and expects the acknowledge exactly two edges later, with the correct data. Split mode is reached by programming a memory-select value that would send the access elsewhere. The routing is then told apart by which bench memory a write lands in and which one a read returns.

// File: rtl/tsx_cpu_pkg.sv
package tsx_cpu_pkg;

  // Memory target codes; the values are the control register select encoding
  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_DM   = 2'b01,
    TGT_CML  = 2'b10,
    TGT_CMH  = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CAP,
    ST_ACK
  } acc_state_e;

  // Split mode overrides the select field: reads from data, writes to low half
  function automatic tgt_e route_target(input logic split, input logic is_read,
                                        input logic [1:0] msel);
    if (split) return is_read ? TGT_DM : TGT_CML;
    return tgt_e'(msel);
  endfunction

  // A memory request is only issued for a real, permitted access
  function automatic logic access_live(input tgt_e tgt, input logic is_read);
    if (tgt == TGT_NONE) return 1'b0;
    if (tgt == TGT_DM && !is_read) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/tsx_sync.sv
module tsx_sync #(
  parameter int                WIDTH   = 2,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/tsx_ctrl_reg.sv
module tsx_ctrl_reg
  import tsx_cpu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   ctrl_byte,
  output logic [STREAM_W-1:0] stream_sel,
  output logic [1:0]          msel,
  output logic                split_on,
  output logic                proc_en
);

  localparam int MS_LO   = STREAM_W;
  localparam int GAP_BIT = STREAM_W + 2;
  localparam int PE_BIT  = DATA_W - 2;
  localparam int SM_BIT  = DATA_W - 1;
  localparam logic [DATA_W-1:0] KEEP =
    (GAP_BIT < PE_BIT) ? ~(DATA_W'(1) << GAP_BIT) : '1;

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & KEEP;
  end

  assign ctrl_byte  = ctrl_q;
  assign stream_sel = ctrl_q[STREAM_W-1:0];
  assign msel       = ctrl_q[MS_LO+1:MS_LO];
  assign split_on   = ctrl_q[SM_BIT];
  assign proc_en    = ctrl_q[PE_BIT];

endmodule

// File: rtl/tsx_access_fsm.sv
module tsx_access_fsm
  import tsx_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_cr,
  input  logic       slot_free,
  input  logic       live,
  input  logic       hold,
  output acc_state_e state,
  output logic       fire,
  output logic       cap_en,
  output logic       ack_on
);

  acc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = is_cr ? ST_ACK : ST_WAIT;
      ST_WAIT: if (slot_free) nxt = ST_CAP;
      ST_CAP:  nxt = ST_ACK;
      ST_ACK:  if (!hold) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign fire   = (state == ST_WAIT) && slot_free && live;
  assign cap_en = (state == ST_CAP);
  assign ack_on = (state == ST_ACK);

endmodule

// File: rtl/tsx_cpu_port.sv
module tsx_cpu_port
  import tsx_cpu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STREAM_W    = 3,
  parameter int CHAN_W      = 5,
  parameter int CMH_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = CHAN_W + 1,
  localparam int MEM_AW     = STREAM_W + CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              rd_nwr,
  input  logic              cs_n,
  inout  wire  [DATA_W-1:0] dbus,
  output logic              ack_n,
  input  logic              slot_free,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_tgt,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] dm_rdata,
  input  logic [DATA_W-1:0] cml_rdata,
  input  logic [CMH_W-1:0]  cmh_rdata,
  output logic              glob_proc_en
);

  // Synchronized strobe and chip select
  logic [1:0] sync_q;
  logic       s_strb, s_csn, s_strb_d;

  tsx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({strobe, cs_n}),
    .q_out (sync_q)
  );
  assign s_strb = sync_q[1];
  assign s_csn  = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_strb_d <= 1'b0;
    else        s_strb_d <= s_strb;
  end

  // Named events
  acc_state_e acc_state;
  logic strb_held, rise_ev, start_ev, cr_sel, cr_wr_ev, cr_rd_ev;
  assign strb_held = s_strb & ~s_csn;
  assign rise_ev   = s_strb & ~s_strb_d & ~s_csn;
  assign start_ev  = rise_ev && (acc_state == ST_IDLE);
  assign cr_sel    = ~addr[ADDR_W-1];
  assign cr_wr_ev  = start_ev & cr_sel & ~rd_nwr;
  assign cr_rd_ev  = start_ev & cr_sel & rd_nwr;

  // Control register
  logic [DATA_W-1:0]   ctrl_byte;
  logic [STREAM_W-1:0] stream_sel;
  logic [1:0]          msel;
  logic                split_on;

  tsx_ctrl_reg #(.DATA_W(DATA_W), .STREAM_W(STREAM_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cr_wr_ev),
    .wdata      (dbus),
    .ctrl_byte  (ctrl_byte),
    .stream_sel (stream_sel),
    .msel       (msel),
    .split_on   (split_on),
    .proc_en    (glob_proc_en)
  );

  // Access capture
  logic [CHAN_W-1:0] chan_q;
  logic              rd_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      rd_q   <= 1'b0;
      wd_q   <= '0;
    end else if (start_ev) begin
      chan_q <= addr[CHAN_W-1:0];
      rd_q   <= rd_nwr;
      wd_q   <= dbus;
    end
  end

  tgt_e tgt;
  logic acc_live, mem_fire, cap_en, ack_on;
  assign tgt      = route_target(split_on, rd_q, msel);
  assign acc_live = access_live(tgt, rd_q);

  tsx_access_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_ev),
    .is_cr     (cr_sel),
    .slot_free (slot_free),
    .live      (acc_live),
    .hold      (strb_held),
    .state     (acc_state),
    .fire      (mem_fire),
    .cap_en    (cap_en),
    .ack_on    (ack_on)
  );

  // Memory port
  assign mem_req   = mem_fire;
  assign mem_we    = ~rd_q;
  assign mem_tgt   = tgt;
  assign mem_addr  = {stream_sel, chan_q};
  assign mem_wdata = wd_q;

  // Read data selection and hold
  logic [DATA_W-1:0] rd_mux, rd_hold;
  always_comb begin
    unique case (tgt)
      TGT_DM:  rd_mux = dm_rdata;
      TGT_CML: rd_mux = cml_rdata;
      TGT_CMH: rd_mux = {{(DATA_W-CMH_W){1'b0}}, cmh_rdata};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rd_hold <= '0;
    else if (cr_rd_ev)       rd_hold <= ctrl_byte;
    else if (cap_en && rd_q) rd_hold <= rd_mux;
  end

  logic bus_oe;
  assign bus_oe = ack_on & rd_q;
  assign dbus   = bus_oe ? rd_hold : 'z;
  assign ack_n  = ~ack_on;

endmodule

// File: rtl/tsx_cpu_port_chk.sv
module tsx_cpu_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] mem_tgt,
  input logic       slot_free,
  input logic       ack_n,
  input logic       bus_oe,
  input logic       split_on,
  input logic       cr_wr_ev,
  input logic       glob_proc_en
);

  assert_req_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> slot_free);

  assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_no_bad_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_tgt == 2'b10 || mem_tgt == 2'b11));

  assert_req_target_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_tgt != 2'b00));

  assert_pe_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_wr_ev |=> $stable(glob_proc_en));

  assert_bus_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !ack_n);

  assert_split_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && split_on) |-> (mem_we ? (mem_tgt == 2'b10) : (mem_tgt == 2'b01)));

endmodule

bind tsx_cpu_port tsx_cpu_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_tgt      (mem_tgt),
  .slot_free    (slot_free),
  .ack_n        (ack_n),
  .bus_oe       (bus_oe),
  .split_on     (split_on),
  .cr_wr_ev     (cr_wr_ev),
  .glob_proc_en (glob_proc_en)
);

// File: tb/tsx_cpu_port_bench.sv
module tsx_cpu_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       strobe = 1'b0;
  logic       rd_nwr = 1'b1;
  logic       cs_n = 1'b1;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_dat = '0;
  wire  [7:0] dbus;
  logic       ack_n, mem_req, mem_we, glob_proc_en;
  logic [1:0] mem_tgt;
  logic [7:0] mem_addr, mem_wdata;
  logic       slot_free = 1'b1;
  logic [7:0] dm_rd, cml_rd;
  logic [2:0] cmh_rd;

  assign dbus = tb_drv ? tb_dat : 8'hzz;

  always #4 clk = ~clk;

  tsx_cpu_port u_tsx_cpu_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .rd_nwr(rd_nwr),
    .cs_n(cs_n), .dbus(dbus), .ack_n(ack_n), .slot_free(slot_free),
    .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .dm_rdata(dm_rd), .cml_rdata(cml_rd),
    .cmh_rdata(cmh_rd), .glob_proc_en(glob_proc_en)
  );

  // Datapath memory model
  function automatic logic [7:0] dm_init(int i);  return 8'(i * 7 + 3); endfunction
  function automatic logic [7:0] cml_init(int i); return 8'(i) ^ 8'hA5; endfunction
  function automatic logic [2:0] cmh_init(int i); return 3'(i); endfunction

  logic [7:0] dm_m  [256];
  logic [7:0] cml_m [256];
  logic [2:0] cmh_m [256];
  int req_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        dm_m[i] <= dm_init(i); cml_m[i] <= cml_init(i); cmh_m[i] <= cmh_init(i);
      end
      dm_rd <= '0; cml_rd <= '0; cmh_rd <= '0;
    end else if (mem_req) begin
      req_cnt <= req_cnt + 1;
      dm_rd  <= dm_m[mem_addr];
      cml_rd <= cml_m[mem_addr];
      cmh_rd <= cmh_m[mem_addr];
      if (mem_we) begin
        case (mem_tgt)
          2'b01: dm_m[mem_addr]  <= mem_wdata;
          2'b10: cml_m[mem_addr] <= mem_wdata;
          2'b11: cmh_m[mem_addr] <= mem_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  // Scoreboard
  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pending = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_pending && !ack_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(dbus === e, t, int'(dbus), int'(e));
      rd_pending = 1'b0;
    end
  end

  task automatic release_bus();
    @(negedge clk);
    strobe = 1'b0; cs_n = 1'b1; tb_drv = 1'b0;
    repeat (3) @(negedge clk);
    chk(ack_n == 1'b1, "R10 ack released after strobe", int'(ack_n), 1);
    @(negedge clk);
  endtask

  task automatic cpu_access(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                            input logic [7:0] exp, input string tag,
                            input int extra_hold, output int lat);
    @(negedge clk);
    addr = a; rd_nwr = rd; cs_n = 1'b0; strobe = 1'b1; tb_drv = !rd; tb_dat = wd;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); rd_pending = 1'b1; end
    lat = 0;
    while (lat < 100) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!ack_n) break;
    end
    for (int k = 0; k < extra_hold; k++) begin
      @(negedge clk);
      chk(ack_n == 1'b0, "R10 ack held while strobe held", int'(ack_n), 0);
    end
    release_bus();
  endtask

  task automatic cr_write(input logic [7:0] v);
    int lat;
    cpu_access(1'b0, 6'h00, v, 8'h00, "", 0, lat);
    chk(lat == 3, "R8 control write latency", lat, 3);
  endtask

  initial begin : main
    int lat;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    chk(ack_n == 1'b1, "R1 ack idle", int'(ack_n), 1);
    chk(mem_req == 1'b0, "R1 no request", int'(mem_req), 0);
    chk(glob_proc_en == 1'b0, "R1 proc enable low", int'(glob_proc_en), 0);
    cpu_access(1'b1, 6'h00, 8'h00, 8'h00, "R1 control reset value", 0, lat);

    // R2 / R3 / R8: write at 0x1F, bit 5 set in data
    cpu_access(1'b0, 6'h1F, 8'h73, 8'h00, "", 0, lat);
    chk(lat == 3, "R8 control write latency", lat, 3);
    chk(glob_proc_en == 1'b1, "R3 proc enable from bit 6", int'(glob_proc_en), 1);
    cpu_access(1'b1, 6'h00, 8'h00, 8'h53, "R2 R3 control readback, bit 5 zero", 0, lat);
    chk(lat == 3, "R8 control read latency", lat, 3);

    // R4 / R5 / R8: select 10 (conn low), stream 3, channel 7
    base = req_cnt;
    cpu_access(1'b0, 6'h27, 8'hC4, 8'h00, "", 0, lat);
    chk(lat == 5, "R8 memory write latency", lat, 5);
    chk(cml_m[3*32+7] == 8'hC4, "R4 R5 conn low write index", int'(cml_m[3*32+7]), 'hC4);
    chk(req_cnt == base + 1, "R9 one request per access", req_cnt - base, 1);
    chk(glob_proc_en == 1'b1, "R3 proc enable held over memory access", int'(glob_proc_en), 1);
    cpu_access(1'b1, 6'h27, 8'h00, 8'hC4, "R4 conn low readback", 0, lat);
    chk(lat == 5, "R8 memory read latency", lat, 5);

    // R6: select 11 (conn high), stream 5
    cr_write(8'h1D);
    chk(glob_proc_en == 1'b0, "R3 proc enable cleared", int'(glob_proc_en), 0);
    cpu_access(1'b0, 6'h20, 8'hFF, 8'h00, "", 0, lat);
    chk(cmh_m[160] == 3'h7, "R6 conn high write", int'(cmh_m[160]), 7);
    cpu_access(1'b1, 6'h20, 8'h00, 8'h07, "R6 conn high upper bits zero", 0, lat);

    // R5: select 01 (data memory), stream 1, channel 10
    cr_write(8'h09);
    cpu_access(1'b1, 6'h2A, 8'h00, dm_init(42), "R5 data memory read", 0, lat);
    base = req_cnt;
    cpu_access(1'b0, 6'h2A, 8'h99, 8'h00, "", 0, lat);
    chk(req_cnt == base, "R5 data memory write issues no request", req_cnt - base, 0);
    chk(dm_m[42] == dm_init(42), "R5 data memory unchanged", int'(dm_m[42]), int'(dm_init(42)));
    chk(cml_m[42] == cml_init(42), "R5 conn low unchanged", int'(cml_m[42]), int'(cml_init(42)));
    cpu_access(1'b1, 6'h2A, 8'h00, dm_init(42), "R5 data memory after ignored write", 0, lat);

    // R5: reserved select 00, stream 2
    cr_write(8'h02);
    base = req_cnt;
    cpu_access(1'b1, 6'h24, 8'h00, 8'h00, "R5 reserved select reads zero", 0, lat);
    cpu_access(1'b0, 6'h24, 8'h5E, 8'h00, "", 0, lat);
    chk(req_cnt == base, "R5 reserved select no request", req_cnt - base, 0);
    chk(cml_m[68] == cml_init(68), "R5 reserved write no change", int'(cml_m[68]), int'(cml_init(68)));

    // R7: split with select 11, stream 2, channel 5
    cr_write(8'h9A);
    cpu_access(1'b0, 6'h25, 8'h3C, 8'h00, "", 0, lat);
    chk(cml_m[69] == 8'h3C, "R7 split write to conn low", int'(cml_m[69]), 'h3C);
    chk(cmh_m[69] == cmh_init(69), "R7 split conn high untouched", int'(cmh_m[69]), int'(cmh_init(69)));
    cpu_access(1'b1, 6'h25, 8'h00, dm_init(69), "R7 split read from data memory", 0, lat);
    cpu_access(1'b1, 6'h00, 8'h00, 8'h9A, "R7 control readback in split", 0, lat);
    cr_write(8'h1A);
    cpu_access(1'b1, 6'h25, 8'h00, {5'b0, cmh_init(69)}, "R7 split cleared reads conn high", 0, lat);

    // R9: slot blocked
    cr_write(8'h13);
    slot_free = 1'b0;
    base = req_cnt;
    @(negedge clk);
    addr = 6'h27; rd_nwr = 1'b1; cs_n = 1'b0; strobe = 1'b1;
    exp_q.push_back(8'hC4); tag_q.push_back("R9 data after blocked slot"); rd_pending = 1'b1;
    repeat (10) @(negedge clk);
    chk(ack_n == 1'b1, "R9 no ack while slot busy", int'(ack_n), 1);
    chk(req_cnt == base, "R9 no request while slot busy", req_cnt - base, 0);
    slot_free = 1'b1;
    lat = 0;
    while (lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!ack_n) break;
    end
    chk(lat == 2, "R9 ack two edges after slot frees", lat, 2);
    chk(req_cnt == base + 1, "R9 single request after slot", req_cnt - base, 1);
    release_bus();

    // R10: strobe without chip select
    base = req_cnt;
    @(negedge clk);
    addr = 6'h21; rd_nwr = 1'b0; cs_n = 1'b1; strobe = 1'b1; tb_drv = 1'b1; tb_dat = 8'h55;
    repeat (8) @(negedge clk);
    chk(ack_n == 1'b1, "R10 no ack without chip select", int'(ack_n), 1);
    chk(req_cnt == base, "R10 no request without chip select", req_cnt - base, 0);
    chk(cml_m[97] == cml_init(97), "R10 no write without chip select", int'(cml_m[97]), int'(cml_init(97)));
    release_bus();

    // R10: long strobe keeps ack low
    cpu_access(1'b1, 6'h00, 8'h00, 8'h13, "R10 control read with long strobe", 4, lat);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule